// File: doc/BRIEF.md
# SPI Register-Access Command Decoder

This block is the slave-side serial front end of a data-converter style peripheral. A host drives a four-wire serial bus in mode 1: MOSI is sampled on the falling SCLK edge and MISO changes on the rising edge. While chip select is held low, the block groups the incoming bits into bytes. It decodes commands that read or write a small 16 x 8 register file, and commands that move conversion results out to the host. All bus inputs are oversampled in the system clock domain through synchronisers, so the block runs on one clock.

Register commands take two bytes. The first holds the opcode nibble and the start address. The second holds the number of registers minus one. The address then steps up by one for each data byte. A separate power-control level, `start_i`, must be high for register access. The block also holds a continuous-read mode, in which each new conversion word is queued for the next frame automatically. In that mode register access is refused until a stop command is received. Conversion words enter through a valid/ready handshake. The block pushes back only while continuous mode is on and a frame is in progress, so that a result cannot be swapped while it is being shifted out.

Top module: `spireg_cmd_decoder`

## Requirements
- R1: Every transition of `cs_n` restarts bit and byte framing, and the command state returns to command decode. A write whose data byte did not complete before `cs_n` rose leaves the register file unchanged, and the next byte after a glitch is decoded as a command.
- R2: Bytes may be separated by idle gaps of any length while `cs_n` stays low, and the transaction result is the same.
- R3: A read is command byte `0010aaaa` (aaaa = start address) followed by a count byte whose low nibble is registers-minus-one. The register data then appears MSB first on MISO during the following bytes, which the host fills with NOP (0xFF). MISO changes after a rising SCLK edge and is valid for the host on the falling edge.
- R4: A write is command byte `0100aaaa`, then the count byte, then one data byte per register. A single-register write takes exactly 24 SCLK cycles.
- R5: After reset, register 0 reads 0x01 and all other registers read 0x00.
- R6: A multi-register transfer increments the address after each data byte, wrapping from 15 to 0.
- R7: A read or write command received while `start_i` is low is ignored. No register changes, and MISO stays 0 for the rest of the frame.
- R8: Command 0x14 enters continuous mode and 0x16 leaves it; the block resets into stopped mode. Read and write commands are ignored in continuous mode in the same way as in R7.
- R9: Command 0x12 shifts out the most recently accepted conversion word, MSB byte first, during the next three bytes of the frame.
- R10: `conv_ready` is low only while continuous mode is on and `cs_n` is low. A word is taken when `conv_valid` and `conv_ready` are both high, and a newer word replaces an older one.
- R11: In continuous mode, a word accepted while `cs_n` is high is shifted out from the first SCLK of the next frame, MSB byte first, over three bytes.
- R12: MISO is 0 while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| start_i | input | 1 | Power-control level; high enables register access |
| conv_data | input | 24 | Conversion result word |
| conv_valid | input | 1 | Conversion word is present |
| conv_ready | output | 1 | Block can accept a conversion word |

## Verification
MISO takes three system clocks to follow a rising SCLK edge: two synchroniser stages plus the output register. A completed byte takes effect four clocks after its eighth falling edge, and `conv_ready` follows `cs_n` within three clocks. The bench holds each SCLK phase for eight clocks. It samples MISO at the last clock before it drives the falling edge, and it checks `conv_ready` only after a full half-period has passed since `cs_n` moved. Register results are always read back through a later frame, so every check observes settled state at the ports.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int BYTE_W = 8;

  localparam logic [3:0] OP_RD_NIB  = 4'h2;
  localparam logic [3:0] OP_WR_NIB  = 4'h4;
  localparam logic [7:0] OP_STOP    = 8'h16;
  localparam logic [7:0] OP_CONT    = 8'h14;
  localparam logic [7:0] OP_SINGLE  = 8'h12;
  localparam logic [7:0] OP_NOP     = 8'hFF;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_CNT_RD,
    ST_CNT_WR,
    ST_RD,
    ST_WR,
    ST_SINK
  } fsm_t;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic cs_s,
  output logic mosi_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_edge
);
  logic [STAGES-1:0] cs_ff, sclk_ff, mosi_ff;
  logic cs_prev, sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_ff     <= '1;
      sclk_ff   <= '0;
      mosi_ff   <= '0;
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_ff     <= {cs_ff[STAGES-2:0], cs_n};
      sclk_ff   <= {sclk_ff[STAGES-2:0], sclk};
      mosi_ff   <= {mosi_ff[STAGES-2:0], mosi};
      cs_prev   <= cs_ff[STAGES-1];
      sclk_prev <= sclk_ff[STAGES-1];
    end
  end

  assign cs_s      = cs_ff[STAGES-1];
  assign mosi_s    = mosi_ff[STAGES-1];
  assign sclk_rise = sclk_ff[STAGES-1] & ~sclk_prev;
  assign sclk_fall = ~sclk_ff[STAGES-1] & sclk_prev;
  assign cs_edge   = cs_ff[STAGES-1] ^ cs_prev;
endmodule

// File: rtl/spireg_framer.sv
module spireg_framer
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              cs_edge,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic [2:0]        bit_cnt,
  output logic              miso
);
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      bit_cnt   <= '0;
      miso      <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (cs_edge || !active) begin
        bit_cnt <= '0;
        if (!active) miso <= 1'b0;
      end else if (sclk_fall) begin
        shreg   <= {shreg[BYTE_W-2:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          rx_byte   <= {shreg[BYTE_W-2:0], mosi_s};
        end
      end else if (sclk_rise) begin
        miso <= tx_byte[3'd7 - bit_cnt];
      end
    end
  end
endmodule

// File: rtl/spireg_regfile.sv
module spireg_regfile #(
  parameter int          ADDR_W = 4,
  parameter int          DATA_W = 8,
  parameter logic [7:0]  RST0   = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH*DATA_W-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic [DATA_W-1:0] RV = (g == 0) ? DATA_W'(RST0) : '0;
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= RV;
      else if (we && addr == ADDR_W'(g))        q <= wdata;
    end
    assign flat[g*DATA_W +: DATA_W] = q;
  end

  assign rdata = flat[addr*DATA_W +: DATA_W];
endmodule

// File: rtl/spireg_cmd_decoder.sv
module spireg_cmd_decoder
  import spireg_pkg::*;
#(
  parameter int         ADDR_W      = 4,
  parameter int         RES_BYTES   = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] RST0_VAL    = 8'h01
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sclk,
  input  logic                        cs_n,
  input  logic                        mosi,
  output logic                        miso,
  input  logic                        start_i,
  input  logic [RES_BYTES*BYTE_W-1:0] conv_data,
  input  logic                        conv_valid,
  output logic                        conv_ready
);
  localparam int RES_W = RES_BYTES * BYTE_W;
  localparam int RL_W  = $clog2(RES_BYTES + 1);

  logic cs_s, mosi_s, sclk_rise, sclk_fall, cs_edge;
  logic byte_done;
  logic [2:0] bit_cnt;
  logic [BYTE_W-1:0] rx_byte, tx_byte, rf_rdata;

  fsm_t              state;
  logic [ADDR_W-1:0] addr, cnt;
  logic              cont_q, res_new, rf_we, accept, byte_go;
  logic [RES_W-1:0]  res_hold, res_buf;
  logic [RL_W-1:0]   res_left;

  spireg_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .cs_s(cs_s), .mosi_s(mosi_s), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .cs_edge(cs_edge)
  );

  spireg_framer framer_i (
    .clk(clk), .rst_n(rst_n), .active(~cs_s), .cs_edge(cs_edge),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .tx_byte(tx_byte), .rx_byte(rx_byte), .byte_done(byte_done),
    .bit_cnt(bit_cnt), .miso(miso)
  );

  assign byte_go = byte_done & ~cs_edge;
  assign rf_we   = byte_go && (state == ST_WR) && start_i;

  spireg_regfile #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W), .RST0(RST0_VAL)) rf_i (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .addr(addr),
    .wdata(rx_byte), .rdata(rf_rdata)
  );

  assign conv_ready = ~(cont_q & ~cs_s);
  assign accept     = conv_valid & conv_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_CMD;
      addr     <= '0;
      cnt      <= '0;
      cont_q   <= 1'b0;
      res_new  <= 1'b0;
      res_hold <= '0;
      res_buf  <= '0;
      res_left <= '0;
      tx_byte  <= '0;
    end else begin
      if (accept) begin
        res_hold <= conv_data;
        if (cont_q) res_new <= 1'b1;
      end

      if (cs_edge) begin
        state    <= ST_CMD;
        cnt      <= '0;
        res_left <= '0;
        tx_byte  <= '0;
        if (!cs_s && cont_q && res_new) begin
          tx_byte  <= res_hold[RES_W-1 -: BYTE_W];
          res_buf  <= res_hold << BYTE_W;
          res_left <= RL_W'(RES_BYTES - 1);
          res_new  <= 1'b0;
        end
      end else if (byte_done) begin
        unique case (state)
          ST_CMD: begin
            if (res_left != '0) begin
              tx_byte  <= res_buf[RES_W-1 -: BYTE_W];
              res_buf  <= res_buf << BYTE_W;
              res_left <= res_left - 1'b1;
            end else begin
              tx_byte  <= '0;
            end
            if (rx_byte[7:4] == OP_RD_NIB || rx_byte[7:4] == OP_WR_NIB) begin
              tx_byte  <= '0;
              res_left <= '0;
              if (start_i && !cont_q) begin
                addr  <= rx_byte[ADDR_W-1:0];
                state <= (rx_byte[7:4] == OP_RD_NIB) ? ST_CNT_RD : ST_CNT_WR;
              end else begin
                state <= ST_SINK;
              end
            end else if (rx_byte == OP_STOP) begin
              cont_q <= 1'b0;
            end else if (rx_byte == OP_CONT) begin
              cont_q <= 1'b1;
            end else if (rx_byte == OP_SINGLE) begin
              tx_byte  <= res_hold[RES_W-1 -: BYTE_W];
              res_buf  <= res_hold << BYTE_W;
              res_left <= RL_W'(RES_BYTES - 1);
            end
          end
          ST_CNT_RD: begin
            cnt     <= rx_byte[ADDR_W-1:0];
            tx_byte <= rf_rdata;
            addr    <= addr + 1'b1;
            state   <= ST_RD;
          end
          ST_RD: begin
            if (cnt == '0) begin
              tx_byte <= '0;
              state   <= ST_CMD;
            end else begin
              cnt     <= cnt - 1'b1;
              tx_byte <= rf_rdata;
              addr    <= addr + 1'b1;
            end
          end
          ST_CNT_WR: begin
            cnt     <= rx_byte[ADDR_W-1:0];
            tx_byte <= '0;
            state   <= ST_WR;
          end
          ST_WR: begin
            tx_byte <= '0;
            addr    <= addr + 1'b1;
            if (cnt == '0) state <= ST_CMD;
            else           cnt   <= cnt - 1'b1;
          end
          default: tx_byte <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spireg_cmd_checker.sv
module spireg_cmd_checker
  import spireg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int RES_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              cs_edge,
  input logic              byte_done,
  input logic [2:0]        bit_cnt,
  input fsm_t              state,
  input logic              cont_q,
  input logic              start_i,
  input logic              rf_we,
  input logic [ADDR_W-1:0] addr,
  input logic              miso,
  input logic              conv_valid,
  input logic              conv_ready,
  input logic [RES_W-1:0]  conv_data,
  input logic [RES_W-1:0]  res_hold
);
  assert_idle_miso_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_s) |-> !miso);

  assert_cs_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_edge |=> (bit_cnt == 3'd0 && state == ST_CMD));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> addr == ADDR_W'($past(addr) + 1'b1));

  assert_start_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !cs_edge && state == ST_CMD && !start_i)
      |=> (state != ST_CNT_RD && state != ST_CNT_WR));

  assert_cont_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !cs_edge && state == ST_CMD && cont_q)
      |=> (state == ST_CMD || state == ST_SINK));

  assert_hold_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && conv_ready) |=> res_hold == $past(conv_data));

  assert_hold_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_valid && conv_ready) |=> $stable(res_hold));
endmodule

bind spireg_cmd_decoder spireg_cmd_checker #(.ADDR_W(ADDR_W), .RES_W(RES_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_edge(cs_edge),
  .byte_done(byte_done), .bit_cnt(bit_cnt), .state(state), .cont_q(cont_q),
  .start_i(start_i), .rf_we(rf_we), .addr(addr), .miso(miso),
  .conv_valid(conv_valid), .conv_ready(conv_ready), .conv_data(conv_data),
  .res_hold(res_hold)
);

// File: tb/spireg_cmd_decoder_tb.sv
module spireg_cmd_decoder_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  logic start_i = 1'b1;
  logic [23:0] conv_data = '0;
  logic conv_valid = 1'b0;
  logic conv_ready;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spireg_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .start_i(start_i), .conv_data(conv_data),
    .conv_valid(conv_valid), .conv_ready(conv_ready)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    @(negedge clk) cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_hi();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic glitch();
    @(negedge clk) cs_n = 1'b1;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic bits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sclk = 1'b1;
      mosi = b[7-i];
      wait_clk(HALF);
      r = {r[6:0], miso};
      sclk = 1'b0;
      wait_clk(HALF);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    bits(b, 8, r);
  endtask

  task automatic reg_write1(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] r;
    cs_lo();
    xfer({4'h4, a}, r);
    xfer(8'h00, r);
    xfer(d, r);
    cs_hi();
  endtask

  task automatic reg_read1(input logic [3:0] a, output logic [7:0] d);
    logic [7:0] r;
    cs_lo();
    xfer({4'h2, a}, r);
    xfer(8'h00, r);
    xfer(8'hFF, d);
    cs_hi();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check8("R12 miso idle", {7'd0, miso}, 8'h00);
    check8("R10 ready at reset", {7'd0, conv_ready}, 8'h01);
    reg_read1(4'h0, d);
    check8("R5 reg0 reset", d, 8'h01);
    reg_read1(4'h9, d);
    check8("R5 reg9 reset", d, 8'h00);
  endtask

  task automatic t_single();
    logic [7:0] d;
    reg_write1(4'h3, 8'hA5);
    reg_read1(4'h3, d);
    check8("R4 R3 reg3 readback", d, 8'hA5);
    reg_write1(4'h4, 8'h3C);
    reg_read1(4'h4, d);
    check8("R4 R3 reg4 readback", d, 8'h3C);
    reg_read1(4'h3, d);
    check8("R4 reg3 kept", d, 8'hA5);
  endtask

  task automatic t_multi();
    logic [7:0] r;
    logic [7:0] exp [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    cs_lo();
    xfer(8'h4E, r);
    xfer(8'h03, r);
    for (int i = 0; i < 4; i++) xfer(exp[i], r);
    cs_hi();
    cs_lo();
    xfer(8'h2E, r);
    xfer(8'h03, r);
    for (int i = 0; i < 4; i++) begin
      xfer(8'hFF, r);
      check8("R6 wrapped multi read", r, exp[i]);
    end
    cs_hi();
  endtask

  task automatic t_gaps();
    logic [7:0] r;
    cs_lo();
    xfer(8'h45, r); wait_clk(50);
    xfer(8'h00, r); wait_clk(70);
    xfer(8'hC3, r);
    cs_hi();
    cs_lo();
    xfer(8'h25, r); wait_clk(90);
    xfer(8'h00, r); wait_clk(40);
    xfer(8'hFF, r);
    cs_hi();
    check8("R2 gapped bytes", r, 8'hC3);
  endtask

  task automatic t_glitch();
    logic [7:0] r, d;
    cs_lo();
    xfer(8'h47, r);
    xfer(8'h00, r);
    bits(8'h99, 3, r);
    cs_hi();
    reg_read1(4'h7, d);
    check8("R1 aborted write", d, 8'h00);
    cs_lo();
    bits(8'hFF, 4, r);
    glitch();
    xfer(8'h47, r);
    xfer(8'h00, r);
    xfer(8'h3C, r);
    cs_hi();
    reg_read1(4'h7, d);
    check8("R1 reframe after glitch", d, 8'h3C);
  endtask

  task automatic t_start();
    logic [7:0] d;
    @(negedge clk) start_i = 1'b0;
    reg_write1(4'h8, 8'h77);
    reg_read1(4'h3, d);
    check8("R7 read blocked", d, 8'h00);
    @(negedge clk) start_i = 1'b1;
    reg_read1(4'h8, d);
    check8("R7 write blocked", d, 8'h00);
    reg_read1(4'h3, d);
    check8("R7 access restored", d, 8'hA5);
  endtask

  task automatic t_results();
    logic [7:0] r, d;
    @(negedge clk);
    conv_data = 24'hABCDEF;
    conv_valid = 1'b1;
    check8("R10 ready when stopped", {7'd0, conv_ready}, 8'h01);
    @(negedge clk) conv_valid = 1'b0;
    cs_lo();
    xfer(8'h12, r);
    xfer(8'hFF, r); check8("R9 byte0", r, 8'hAB);
    xfer(8'hFF, r); check8("R9 byte1", r, 8'hCD);
    xfer(8'hFF, r); check8("R9 byte2", r, 8'hEF);
    cs_hi();
    cs_lo();
    xfer(8'h14, r);
    cs_hi();
    cs_lo();
    check8("R10 ready low in frame", {7'd0, conv_ready}, 8'h00);
    xfer(8'h23, r);
    xfer(8'h00, r);
    xfer(8'hFF, r);
    check8("R8 read blocked in cont mode", r, 8'h00);
    cs_hi();
    check8("R10 ready after frame", {7'd0, conv_ready}, 8'h01);
    @(negedge clk);
    conv_data = 24'h999999; conv_valid = 1'b1;
    @(negedge clk);
    conv_data = 24'h123456;
    @(negedge clk) conv_valid = 1'b0;
    cs_lo();
    xfer(8'hFF, r); check8("R11 auto byte0", r, 8'h12);
    xfer(8'hFF, r); check8("R11 auto byte1", r, 8'h34);
    xfer(8'hFF, r); check8("R11 auto byte2", r, 8'h56);
    xfer(8'h16, r);
    cs_hi();
    reg_read1(4'h3, d);
    check8("R8 access after stop", d, 8'hA5);
    check8("R12 miso idle end", {7'd0, miso}, 8'h00);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_single();
    t_multi();
    t_gaps();
    t_glitch();
    t_start();
    t_results();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule